// File: doc/BRIEF.md
# Serial ADC Frame Read Controller

This block is the host side of a link to a serial successive-approximation converter. It owns chip select and the serial clock, samples the converter's data line, and hands back each 12-bit two's complement result, widened to 16 bits, with a one-cycle valid strobe. Chip select falls exactly when a conversion is wanted, because that edge fixes the sampling instant.

Three requests drive it. A read request runs a full 16-edge frame. A sleep request runs a cut-short 8-edge frame, which leaves the converter in shutdown. A wake request runs a full dummy frame whose result is discarded. The controller tracks whether the converter is powered. A read that arrives while it is shut down first runs the wake dummy frame and then the read. Requests that arrive while a frame or the quiet gap is in progress are held until the controller is idle. The serial clock half period and the minimum chip-select-high gap are run-time inputs.

Top module: `adc_frame_rd`

## Requirements
- R1: After reset, csN is high, sclk is low, sampleValid and frameErr are low and convAwake is high.
- R2: A read frame keeps csN low across exactly 16 rising sclk edges. Each sclk high and low phase lasts divHalf system clocks, where a value of 0 acts as 1. sclk is low whenever csN is high.
- R3: sdata is sampled at every rising sclk edge. The first bit is the one present when csN falls. The 16 bits arrive as 4 leading bits followed by 12 data bits, most significant first.
- R4: At the end of a read frame, the 12 data bits are sign-extended to 16 bits on sampleData. sampleValid is high for one cycle, in the cycle that csN returns high.
- R5: frameErr is high together with sampleValid when any of the 4 leading bits was 1, and low otherwise.
- R6: A sleep request while the converter is powered runs a frame of exactly 8 rising sclk edges with no sampleValid. convAwake goes low when that frame ends.
- R7: A read request while the converter is shut down first runs a 16-edge dummy frame with no sampleValid. The read frame follows, and convAwake is high after the dummy frame.
- R8: A wake request while the converter is shut down runs one 16-edge dummy frame with no sampleValid. A wake request while it is powered starts no frame. A sleep request while it is shut down starts no frame.
- R9: Between two frames, csN stays high for at least quietCycles system clocks, and never less than 1.
- R10: Requests arriving during a frame or quiet gap are kept and served once the controller is idle. When the controller is idle, the order of service is: wake dummy first, then read, then sleep.
- R11: convAwake changes only in the cycle that csN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| readReq | input | 1 | Request one converted sample |
| sleepReq | input | 1 | Request a shutdown frame |
| wakeReq | input | 1 | Request a wake dummy frame |
| divHalf | input | 8 | sclk half period in system clocks (0 acts as 1) |
| quietCycles | input | 8 | Minimum csN-high gap between frames |
| sdata | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sampleData | output | 16 | Sign-extended conversion result |
| sampleValid | output | 1 | One-cycle strobe for sampleData |
| frameErr | output | 1 | Leading bits were not all zero |
| convAwake | output | 1 | Converter is assumed to be powered |

## Verification
The read path is exercised with frame words at both ends of the two's complement range, with zero, with minus one and with mid-scale values. These show whether the sign extension and the bit order are right. Words with a set leading bit separate the error flag from the data path. Several divider settings, including zero, show whether the phase timing follows the input. The mode sequences combine sleep, wake and read in different orders and from both power states, and send simultaneous and mid-frame requests. Each sequence is told apart by its count of frames and edges, its valid pulses and the final power state.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  // Kind of frame that the control unit is currently running.
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_DUMMY = 2'd1,
    KIND_SLEEP = 2'd2
  } frameKind_t;

  // Strobes passed from the control unit to the datapath.
  typedef struct packed {
    logic clear;   // empty the shift register at frame start
    logic shift;   // capture sdata on this rising sclk
    logic emit;    // publish the result of a read frame
  } dpStrobe_t;

endpackage

// File: rtl/adc_frame_ctl.sv
module adc_frame_ctl
  import adc_frame_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int QUIET_W     = 8,
  parameter int FRAME_EDGES = 16,
  parameter int SLEEP_EDGES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               readReq,
  input  logic               sleepReq,
  input  logic               wakeReq,
  input  logic [DIV_W-1:0]   divHalf,
  input  logic [QUIET_W-1:0] quietCycles,
  output logic               csN,
  output logic               sclk,
  output logic               convAwake,
  output dpStrobe_t          strobe
);

  localparam int EDGE_W = $clog2(FRAME_EDGES + 1);
  localparam logic [EDGE_W-1:0] FULL_TARGET  = EDGE_W'(FRAME_EDGES);
  localparam logic [EDGE_W-1:0] SHORT_TARGET = EDGE_W'(SLEEP_EDGES);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_QUIET} ctlState_t;

  ctlState_t          state;
  frameKind_t         kind;
  logic               csNReg;
  logic               sclkReg;
  logic               awakeReg;
  logic [DIV_W-1:0]   phaseCnt;
  logic [EDGE_W-1:0]  edgeCnt;
  logic [QUIET_W-1:0] quietCnt;
  logic               readPend;
  logic               sleepPend;
  logic               wakePend;

  logic [DIV_W-1:0]   halfLim;
  logic [QUIET_W-1:0] quietLim;
  logic [EDGE_W-1:0]  edgeTarget;
  logic               tick;
  logic               lastFall;
  logic               isIdle;
  logic               needWake;
  logic               launchRead;
  logic               launchSleep;
  logic               launchAny;
  logic               clrRead;
  logic               clrSleep;
  logic               clrWake;

  always_comb begin
    halfLim    = (divHalf == '0) ? '0 : divHalf - 1'b1;
    quietLim   = (quietCycles == '0) ? '0 : quietCycles - 1'b1;
    edgeTarget = (kind == KIND_SLEEP) ? SHORT_TARGET : FULL_TARGET;
    tick       = (state == ST_FRAME) && (phaseCnt >= halfLim);
    lastFall   = tick && sclkReg && (edgeCnt == edgeTarget);
  end

  // Idle decision: a wake dummy frame outranks a read, and a read outranks a sleep.
  always_comb begin
    isIdle      = (state == ST_IDLE);
    needWake    = isIdle && !awakeReg && (readPend || wakePend);
    launchRead  = isIdle && awakeReg && readPend;
    launchSleep = isIdle && awakeReg && !readPend && sleepPend;
    launchAny   = needWake || launchRead || launchSleep;
    clrRead     = launchRead;
    clrWake     = needWake || (isIdle && awakeReg);
    clrSleep    = launchSleep ||
                  (isIdle && !awakeReg && !readPend && !wakePend);
  end

  always_comb begin
    strobe.clear = launchAny;
    strobe.shift = tick && !sclkReg;
    strobe.emit  = lastFall && (kind == KIND_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPend  <= 1'b0;
      sleepPend <= 1'b0;
      wakePend  <= 1'b0;
    end else begin
      readPend  <= (readPend  && !clrRead)  || readReq;
      sleepPend <= (sleepPend && !clrSleep) || sleepReq;
      wakePend  <= (wakePend  && !clrWake)  || wakeReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= KIND_READ;
      csNReg   <= 1'b1;
      sclkReg  <= 1'b0;
      awakeReg <= 1'b1;
      phaseCnt <= '0;
      edgeCnt  <= '0;
      quietCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launchAny) begin
            if (needWake)        kind <= KIND_DUMMY;
            else if (launchRead) kind <= KIND_READ;
            else                 kind <= KIND_SLEEP;
            csNReg   <= 1'b0;
            phaseCnt <= '0;
            edgeCnt  <= '0;
            state    <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (tick) begin
            phaseCnt <= '0;
            if (lastFall) begin
              sclkReg  <= 1'b0;
              csNReg   <= 1'b1;
              quietCnt <= '0;
              state    <= ST_QUIET;
              if (kind == KIND_SLEEP)      awakeReg <= 1'b0;
              else if (kind == KIND_DUMMY) awakeReg <= 1'b1;
            end else begin
              sclkReg <= !sclkReg;
              if (!sclkReg) edgeCnt <= edgeCnt + 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_QUIET: begin
          if (quietCnt >= quietLim) state <= ST_IDLE;
          else                      quietCnt <= quietCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN       = csNReg;
  assign sclk      = sclkReg;
  assign convAwake = awakeReg;

endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int LEAD_BITS = 4,
  parameter int DATA_BITS = 12,
  parameter int OUT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             sdata,
  output logic [OUT_W-1:0] sampleData,
  output logic             sampleValid,
  output logic             frameErr
);

  localparam int FRAME_BITS = LEAD_BITS + DATA_BITS;
  localparam int EXT_BITS   = OUT_W - DATA_BITS;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [OUT_W-1:0]      extended;
  logic                  leadBad;

  always_comb begin
    extended = {{EXT_BITS{shiftReg[DATA_BITS-1]}}, shiftReg[DATA_BITS-1:0]};
    leadBad  = |shiftReg[FRAME_BITS-1:DATA_BITS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clear) begin
      shiftReg <= '0;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleData  <= '0;
      sampleValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      sampleValid <= strobe.emit;
      frameErr    <= strobe.emit && leadBad;
      if (strobe.emit) sampleData <= extended;
    end
  end

endmodule

// File: rtl/adc_frame_rd.sv
module adc_frame_rd
  import adc_frame_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int QUIET_W     = 8,
  parameter int LEAD_BITS   = 4,
  parameter int DATA_BITS   = 12,
  parameter int OUT_W       = 16,
  parameter int SLEEP_EDGES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               readReq,
  input  logic               sleepReq,
  input  logic               wakeReq,
  input  logic [DIV_W-1:0]   divHalf,
  input  logic [QUIET_W-1:0] quietCycles,
  input  logic               sdata,
  output logic               csN,
  output logic               sclk,
  output logic [OUT_W-1:0]   sampleData,
  output logic               sampleValid,
  output logic               frameErr,
  output logic               convAwake
);

  localparam int FRAME_EDGES = LEAD_BITS + DATA_BITS;

  dpStrobe_t strobe;

  adc_frame_ctl #(
    .DIV_W      (DIV_W),
    .QUIET_W    (QUIET_W),
    .FRAME_EDGES(FRAME_EDGES),
    .SLEEP_EDGES(SLEEP_EDGES)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .readReq    (readReq),
    .sleepReq   (sleepReq),
    .wakeReq    (wakeReq),
    .divHalf    (divHalf),
    .quietCycles(quietCycles),
    .csN        (csN),
    .sclk       (sclk),
    .convAwake  (convAwake),
    .strobe     (strobe)
  );

  adc_frame_dp #(
    .LEAD_BITS(LEAD_BITS),
    .DATA_BITS(DATA_BITS),
    .OUT_W    (OUT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sdata      (sdata),
    .sampleData (sampleData),
    .sampleValid(sampleValid),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/adc_frame_chk.sv
module adc_frame_chk #(
  parameter int OUT_W     = 16,
  parameter int DATA_BITS = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sclk,
  input logic [OUT_W-1:0] sampleData,
  input logic             sampleValid,
  input logic             frameErr,
  input logic             convAwake
);

  AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R2

  AST_RESULT_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $rose(csN));  // R4

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);  // R4

  AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sampleData[OUT_W-1:DATA_BITS] ==
                     {(OUT_W-DATA_BITS){sampleData[DATA_BITS-1]}}));  // R4

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> sampleValid);  // R5

  AST_AWAKE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(convAwake) |-> $rose(csN));  // R11

endmodule

bind adc_frame_rd adc_frame_chk #(
  .OUT_W    (OUT_W),
  .DATA_BITS(DATA_BITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .sclk       (sclk),
  .sampleData (sampleData),
  .sampleValid(sampleValid),
  .frameErr   (frameErr),
  .convAwake  (convAwake)
);

// File: tb/adc_frame_rd_bench.sv
`timescale 1ns/1ps
module adc_frame_rd_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        readReq = 1'b0;
  logic        sleepReq = 1'b0;
  logic        wakeReq = 1'b0;
  logic [7:0]  divHalf = 8'd2;
  logic [7:0]  quietCycles = 8'd4;
  logic        sdata;
  logic        csN;
  logic        sclk;
  logic [15:0] sampleData;
  logic        sampleValid;
  logic        frameErr;
  logic        convAwake;

  always #10 clk = ~clk;

  adc_frame_rd u_adc_frame_rd (
    .clk        (clk),
    .rstN       (rstN),
    .readReq    (readReq),
    .sleepReq   (sleepReq),
    .wakeReq    (wakeReq),
    .divHalf    (divHalf),
    .quietCycles(quietCycles),
    .sdata      (sdata),
    .csN        (csN),
    .sclk       (sclk),
    .sampleData (sampleData),
    .sampleValid(sampleValid),
    .frameErr   (frameErr),
    .convAwake  (convAwake)
  );

  // Converter model: first bit present at csN fall, next bit after each falling sclk.
  logic [15:0] txWord = 16'h0000;
  int bitIdx = 0;
  always @(negedge sclk or posedge csN)
    if (csN) bitIdx <= 0;
    else     bitIdx <= bitIdx + 1;
  assign sdata = (!csN && bitIdx < 16) ? txWord[15 - bitIdx] : 1'b0;

  // Frame observers.
  int riseCnt = 0, lastRises = 0, frameCnt = 0, validCnt = 0;
  int highRun = 0, lastHigh = 0;
  realtime riseT = 0.0, highWidth = 0.0;
  always @(posedge sclk or negedge csN)
    if (sclk) riseCnt <= riseCnt + 1;
    else      riseCnt <= 0;
  always @(posedge csN) lastRises <= riseCnt;
  always @(negedge csN) frameCnt <= frameCnt + 1;
  always @(posedge sclk) riseT = $realtime;
  always @(negedge sclk) highWidth = $realtime - riseT;
  always @(posedge clk) begin
    if (sampleValid) validCnt <= validCnt + 1;
    if (csN) highRun <= highRun + 1;
    else if (highRun != 0) begin
      lastHigh <= highRun;
      highRun  <= 0;
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit rd, input bit sl, input bit wk);
    @(negedge clk);
    readReq = rd; sleepReq = sl; wakeReq = wk;
    @(negedge clk);
    readReq = 1'b0; sleepReq = 1'b0; wakeReq = 1'b0;
  endtask

  task automatic waitValid(output bit seen, output logic [15:0] data,
                           output logic err);
    seen = 1'b0; data = '0; err = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (sampleValid) begin
        seen = 1'b1; data = sampleData; err = frameErr;
      end
    end
  endtask

  task automatic waitQuiet();
    int run = 0;
    for (int i = 0; i < 8000 && run < 64; i++) begin
      @(negedge clk);
      run = csN ? run + 1 : 0;
    end
  endtask

  // Vector: {divHalf[3:0], frame word[15:0]}
  localparam logic [19:0] VEC [0:7] = '{
    20'h1_07FF, 20'h2_0800, 20'h0_0000, 20'h3_0FFF,
    20'h5_0123, 20'h2_8555, 20'h1_1ABC, 20'h4_0001
  };

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit seen;
    logic [15:0] got;
    logic gotErr;
    int f0, v0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(csN == 1'b1, "R1", "csN", csN, 1);
    check(sclk == 1'b0, "R1", "sclk", sclk, 0);
    check(sampleValid == 1'b0 && frameErr == 1'b0, "R1", "valid/err",
          {sampleValid, frameErr}, 0);
    check(convAwake == 1'b1, "R1", "convAwake", convAwake, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5: table of read frames
    foreach (VEC[k]) begin
      logic [15:0] w;
      int d;
      logic [15:0] expData;
      w = VEC[k][15:0];
      d = (VEC[k][19:16] == 4'd0) ? 1 : int'(VEC[k][19:16]);
      expData = {{4{w[11]}}, w[11:0]};
      txWord = w;
      divHalf = {4'd0, VEC[k][19:16]};
      pulse(1'b1, 1'b0, 1'b0);
      waitValid(seen, got, gotErr);
      check(seen, "R4", "valid seen", seen, 1);
      check(got == expData, "R3_R4", "sampleData", got, expData);
      check(gotErr == (|w[15:12]), "R5", "frameErr", gotErr, |w[15:12]);
      waitQuiet();
      check(lastRises == 16, "R2", "edges per read frame", lastRises, 16);
      check(highWidth == real'(d * 20), "R2", "sclk high width ns",
            longint'(highWidth), d * 20);
    end

    // R6 R11: sleep frame
    divHalf = 8'd2;
    f0 = frameCnt; v0 = validCnt;
    pulse(1'b0, 1'b1, 1'b0);
    @(negedge csN); @(negedge clk);
    check(convAwake == 1'b1, "R11", "awake during sleep frame", convAwake, 1);
    waitQuiet();
    check(frameCnt == f0 + 1, "R6", "frame count", frameCnt, f0 + 1);
    check(lastRises == 8, "R6", "edges in sleep frame", lastRises, 8);
    check(validCnt == v0, "R6", "valid pulses", validCnt, v0);
    check(convAwake == 1'b0, "R6", "convAwake", convAwake, 0);

    // R8: sleep while shut down starts nothing
    f0 = frameCnt;
    pulse(1'b0, 1'b1, 1'b0);
    waitQuiet();
    check(frameCnt == f0, "R8", "sleep while asleep frames", frameCnt, f0);

    // R7: read while shut down -> dummy then read
    txWord = 16'h0456;
    f0 = frameCnt; v0 = validCnt;
    pulse(1'b1, 1'b0, 1'b0);
    waitValid(seen, got, gotErr);
    check(seen && got == 16'h0456, "R7", "data after wake", got, 16'h0456);
    waitQuiet();
    check(frameCnt == f0 + 2, "R7", "frames", frameCnt, f0 + 2);
    check(validCnt == v0 + 1, "R7", "valid pulses", validCnt, v0 + 1);
    check(convAwake == 1'b1, "R7", "convAwake", convAwake, 1);

    // R8: wake while powered starts nothing
    f0 = frameCnt;
    pulse(1'b0, 1'b0, 1'b1);
    waitQuiet();
    check(frameCnt == f0, "R8", "wake while awake frames", frameCnt, f0);

    // R8: wake from shutdown -> one dummy frame
    pulse(1'b0, 1'b1, 1'b0);
    waitQuiet();
    f0 = frameCnt; v0 = validCnt;
    pulse(1'b0, 1'b0, 1'b1);
    waitQuiet();
    check(frameCnt == f0 + 1, "R8", "dummy frames", frameCnt, f0 + 1);
    check(lastRises == 16, "R8", "dummy edges", lastRises, 16);
    check(validCnt == v0, "R8", "dummy valid", validCnt, v0);
    check(convAwake == 1'b1, "R8", "convAwake", convAwake, 1);

    // R9 R10: held requests, priority read before sleep, quiet gap
    quietCycles = 8'd20;
    txWord = 16'h0ABC;
    f0 = frameCnt; v0 = validCnt;
    pulse(1'b1, 1'b1, 1'b0);
    @(negedge csN);
    pulse(1'b1, 1'b0, 1'b0);
    waitQuiet();
    check(frameCnt == f0 + 3, "R10", "frames served", frameCnt, f0 + 3);
    check(validCnt == v0 + 2, "R10", "reads served", validCnt, v0 + 2);
    check(lastRises == 8, "R10", "sleep served last", lastRises, 8);
    check(convAwake == 1'b0, "R10", "convAwake", convAwake, 0);
    check(lastHigh >= 20, "R9", "quiet gap cycles", lastHigh, 20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule